// File: doc/BRIEF.md
# Repeater Port Jabber and Partition Guard

This block watches one repeater port, one bit time at a time. A bit-time strobe advances every timer. The block reads four line states: transmit activity, receive carrier, collision, and the strobe itself. It drives two flags.

The first flag is a jabber lockout. If the port transmits without a break for too long, the lockout cuts its output for a fixed hold window and then releases it.

The second flag is a partition flag. It isolates the segment after a run of packets that each saw a collision, or after a single collision that lasts too long. The flag clears again once the segment carries a packet that stays free of collisions for a full clean window.

The block keeps counting and timing while the port is partitioned, so it can see the clean packet that reconnects it. Short gaps in carrier or transmit activity are bridged by recovery times, so a brief dropout does not split one packet into two.

Top module: `rptr_port_guard`

## Requirements
- R1: After reset, both `jab_lock_o` and `part_o` are low.
- R2: `jab_lock_o` stays low through 65,536 consecutive ticks with `tx_active_i` high. It rises on the 65,537th such tick.
- R3: Once raised, `jab_lock_o` stays high for exactly 96 ticks and then falls. The continuous-transmit count then starts again from zero.
- R4: A single tick with `tx_active_i` low clears the continuous-transmit count.
- R5: A packet that saw `col_i` high on at least one tick counts as a collision packet. `part_o` rises when the 32nd consecutive collision packet ends. After 31 it stays low.
- R6: `part_o` rises on the 2,049th consecutive tick with `col_i` high. After 2,048 such ticks it is still low.
- R7: While partitioned, `part_o` falls on the 512th tick of `rx_active_i` or `tx_active_i` activity in a packet that has seen no collision. After the 511th tick it is still high.
- R8: A packet that reaches 512 collision-free active ticks resets the consecutive-collision count to zero. A shorter collision-free packet leaves the count unchanged.
- R9: A packet ends only after `rx_active_i` has been low for 3 ticks. A gap of 2 ticks does not split a packet.
- R10: A packet ends only after `tx_active_i` has been low for 10 ticks. A gap of 9 ticks does not split a packet.
- R11: Every count and timer advances only on clock cycles with `bit_tick_i` high. Both outputs hold their value on cycles without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe, once per bit time |
| tx_active_i | input | 1 | Port is transmitting |
| col_i | input | 1 | Collision present |
| rx_active_i | input | 1 | Carrier or receive activity present |
| jab_lock_o | output | 1 | Transmit output disabled by jabber protection |
| part_o | output | 1 | Segment partitioned |

## Verification
The bench samples each flag one tick before and one tick after every threshold: 65,536/65,537 transmit ticks, 2,048/2,049 collision ticks, 511/512 clean ticks, and 31/32 collision packets. An off-by-one timer fails one side of those pairs. Gaps of 2 and 9 ticks inside a packet check the recovery times: a design that ends packets too early counts one bursty packet many times and partitions early. A short clean packet placed between collision runs catches a design that resets the count without the full window. A transmit break in the middle of a long transmission catches a jabber count that never clears. Ticks given only on every second cycle catch timers that count clock cycles instead of bit times.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef struct packed {
    logic busy;  // inside a packet
    logic done;  // packet ends on this tick
    logic data;  // tick with rx or tx active
  } pkt_evt_t;
endpackage

// File: rtl/rpg_quiet.sv
module rpg_quiet #(
  parameter int LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic idle_o
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (line_i)                  cnt_d = '0;
    else if (cnt_q == W'(LIMIT)) cnt_d = cnt_q;
    else                         cnt_d = cnt_q + 1'b1;
  end

  assign idle_o = (cnt_d == W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= W'(LIMIT);
    else if (tick_i) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rpg_activity.sv
module rpg_activity
  import rpg_pkg::*;
#(
  parameter int TX_RECOV  = 10,
  parameter int CRS_RECOV = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     tx_i,
  input  logic     rx_i,
  input  logic     col_i,
  output pkt_evt_t evt_o
);
  localparam int NCH = 2;

  logic [NCH-1:0] line, idle;
  logic           act, all_idle, in_pkt_q;

  assign line = {tx_i, rx_i};

  for (genvar g = 0; g < NCH; g++) begin : g_quiet
    localparam int LIM = (g == 0) ? CRS_RECOV : TX_RECOV;
    rpg_quiet #(.LIMIT(LIM)) u_quiet (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .line_i (line[g]),
      .idle_o (idle[g])
    );
  end

  assign act      = rx_i | tx_i | col_i;
  assign all_idle = &idle & ~col_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_pkt_q <= 1'b0;
    else if (tick_i) begin
      if (act)           in_pkt_q <= 1'b1;
      else if (all_idle) in_pkt_q <= 1'b0;
    end
  end

  assign evt_o.busy = in_pkt_q;
  assign evt_o.done = tick_i & in_pkt_q & all_idle;
  assign evt_o.data = tick_i & (rx_i | tx_i);

  assert_end_after_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_pkt_q) |-> $past(tick_i && !rx_i && !tx_i && !col_i));
endmodule

// File: rtl/rpg_jabber.sv
module rpg_jabber #(
  parameter int JAB_LIMIT = 65536,
  parameter int JAB_HOLD  = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic tx_i,
  output logic lock_o
);
  localparam int RW = $clog2(JAB_LIMIT + 1);
  localparam int HW = $clog2(JAB_HOLD);

  logic [RW-1:0] run_q;
  logic [HW-1:0] hold_q;
  logic          lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      hold_q <= '0;
      lock_q <= 1'b0;
    end else if (tick_i) begin
      if (lock_q) begin
        run_q <= '0;
        if (hold_q == HW'(JAB_HOLD - 1)) begin
          lock_q <= 1'b0;
          hold_q <= '0;
        end else begin
          hold_q <= hold_q + 1'b1;
        end
      end else if (!tx_i) begin
        run_q <= '0;
      end else if (run_q == RW'(JAB_LIMIT)) begin
        lock_q <= 1'b1;
        run_q  <= '0;
        hold_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign lock_o = lock_q;

  assert_lock_needs_tx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(tx_i && tick_i));
  assert_hold_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q < HW'(JAB_HOLD));
  assert_release_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> $past(tick_i));
endmodule

// File: rtl/rpg_partition.sv
module rpg_partition
  import rpg_pkg::*;
#(
  parameter int COL_LIMIT = 32,
  parameter int LONG_COL  = 2048,
  parameter int CLEAN_WIN = 512
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     col_i,
  input  pkt_evt_t evt_i,
  output logic     part_o
);
  localparam int CW = $clog2(LONG_COL + 1);
  localparam int LW = $clog2(CLEAN_WIN + 1);
  localparam int KW = $clog2(COL_LIMIT + 1);

  logic [CW-1:0] col_run_q;
  logic [LW-1:0] len_q;
  logic [KW-1:0] consec_q;
  logic          saw_col_q, part_q;
  logic          long_hit, clean_hit, count_hit;

  assign long_hit  = tick_i & col_i & (col_run_q == CW'(LONG_COL));
  assign clean_hit = evt_i.data & ~col_i & ~saw_col_q & (len_q == LW'(CLEAN_WIN - 1));
  assign count_hit = evt_i.done & saw_col_q & (consec_q >= KW'(COL_LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_run_q <= '0;
    end else if (tick_i) begin
      if (!col_i)                           col_run_q <= '0;
      else if (col_run_q != CW'(LONG_COL))  col_run_q <= col_run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saw_col_q <= 1'b0;
      len_q     <= '0;
    end else if (evt_i.done) begin
      saw_col_q <= 1'b0;
      len_q     <= '0;
    end else begin
      if (tick_i && col_i) saw_col_q <= 1'b1;
      if (evt_i.data && len_q != LW'(CLEAN_WIN)) len_q <= len_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      consec_q <= '0;
    end else if (clean_hit) begin
      consec_q <= '0;
    end else if (evt_i.done && saw_col_q && consec_q != KW'(COL_LIMIT)) begin
      consec_q <= consec_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   part_q <= 1'b0;
    else if (clean_hit)            part_q <= 1'b0;
    else if (long_hit | count_hit) part_q <= 1'b1;
  end

  assign part_o = part_q;

  assert_consec_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consec_q <= KW'(COL_LIMIT));
  assert_part_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(part_q) |-> $past(tick_i));
  assert_reconnect_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(part_q) |-> $past(evt_i.data && !col_i));
  assert_clean_zeroes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean_hit |=> consec_q == '0);
endmodule

// File: rtl/rptr_port_guard.sv
module rptr_port_guard
  import rpg_pkg::*;
#(
  parameter int JAB_LIMIT = 65536,
  parameter int JAB_HOLD  = 96,
  parameter int COL_LIMIT = 32,
  parameter int LONG_COL  = 2048,
  parameter int CLEAN_WIN = 512,
  parameter int TX_RECOV  = 10,
  parameter int CRS_RECOV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic tx_active_i,
  input  logic col_i,
  input  logic rx_active_i,
  output logic jab_lock_o,
  output logic part_o
);
  pkt_evt_t evt;

  rpg_activity #(.TX_RECOV(TX_RECOV), .CRS_RECOV(CRS_RECOV)) u_activity (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (bit_tick_i),
    .tx_i   (tx_active_i),
    .rx_i   (rx_active_i),
    .col_i  (col_i),
    .evt_o  (evt)
  );

  rpg_partition #(.COL_LIMIT(COL_LIMIT), .LONG_COL(LONG_COL), .CLEAN_WIN(CLEAN_WIN)) u_partition (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (bit_tick_i),
    .col_i  (col_i),
    .evt_i  (evt),
    .part_o (part_o)
  );

  rpg_jabber #(.JAB_LIMIT(JAB_LIMIT), .JAB_HOLD(JAB_HOLD)) u_jabber (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (bit_tick_i),
    .tx_i   (tx_active_i),
    .lock_o (jab_lock_o)
  );

  assert_hold_without_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(part_o) && $stable(jab_lock_o));
endmodule

// File: tb/rptr_port_guard_bench.sv
`timescale 1ns/1ps
module rptr_port_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, tx = 1'b0, col = 1'b0, rx = 1'b0;
  logic lock, part;
  int   checks = 0, fails = 0;
  logic  exp_part_q[$];
  logic  exp_lock_q[$];
  string tag_q[$];
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  rptr_port_guard u_rptr_port_guard (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .tx_active_i(tx),
    .col_i(col), .rx_active_i(rx), .jab_lock_o(lock), .part_o(part)
  );

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    #1;
    while (tag_q.size() > 0) begin
      logic ep, el;
      string t;
      ep = exp_part_q.pop_front();
      el = exp_lock_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if (part !== ep || lock !== el) begin
        fails++;
        $display("FAIL %s: part=%b lock=%b expected part=%b lock=%b", t, part, lock, ep, el);
      end
    end
  end

  task automatic expect_st(logic p, logic l, string t);
    exp_part_q.push_back(p);
    exp_lock_q.push_back(l);
    tag_q.push_back(t);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic col_pkt(int len, int gap);
    rx = 1'b1; col = 1'b1; step(len);
    rx = 1'b0; col = 1'b0; step(gap);
  endtask

  task automatic clean_pkt(int len);
    rx = 1'b1; step(len);
    rx = 1'b0; step(12);
  endtask

  task automatic reconnect(string t);
    rx = 1'b1; step(511);
    expect_st(1'b1, 1'b0, {t, " 511 clean ticks"});
    step(1);
    expect_st(1'b0, 1'b0, {t, " 512 clean ticks"});
    step(88);
    rx = 1'b0; step(12);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_st(1'b0, 1'b0, "R1 reset state");

    for (int i = 0; i < 31; i++) col_pkt(20, 12);
    expect_st(1'b0, 1'b0, "R5 after 31 collision packets");
    col_pkt(20, 12);
    expect_st(1'b1, 1'b0, "R5 after 32 collision packets");
    reconnect("R7");

    for (int i = 0; i < 31; i++) col_pkt(20, 12);
    expect_st(1'b0, 1'b0, "R8 count cleared by clean packet");
    clean_pkt(600);

    for (int i = 0; i < 20; i++) col_pkt(20, 12);
    clean_pkt(100);
    for (int i = 0; i < 12; i++) col_pkt(20, 12);
    expect_st(1'b1, 1'b0, "R8 short clean packet keeps count");
    reconnect("R7 partitioned monitoring");

    // carrier gaps of 2 ticks: one packet
    for (int i = 0; i < 40; i++) col_pkt(5, 2);
    step(12);
    for (int i = 0; i < 30; i++) col_pkt(20, 12);
    expect_st(1'b0, 1'b0, "R9 2-tick rx gaps merge into one packet");
    col_pkt(20, 12);
    expect_st(1'b1, 1'b0, "R9 merged packet counted once");
    reconnect("R9");

    // transmit gaps of 9 ticks: one packet
    for (int i = 0; i < 40; i++) begin
      tx = 1'b1; col = 1'b1; step(5);
      tx = 1'b0; col = 1'b0; step(9);
    end
    step(12);
    expect_st(1'b0, 1'b0, "R10 9-tick tx gaps merge into one packet");
    clean_pkt(600);
    for (int i = 0; i < 32; i++) begin
      tx = 1'b1; col = 1'b1; step(5);
      tx = 1'b0; col = 1'b0; step(10);
    end
    expect_st(1'b1, 1'b0, "R10 10-tick tx gaps split packets");
    reconnect("R10");

    rx = 1'b1; col = 1'b1; step(2048);
    expect_st(1'b0, 1'b0, "R6 2048 collision ticks");
    step(1);
    expect_st(1'b1, 1'b0, "R6 2049 collision ticks");
    rx = 1'b0; col = 1'b0; step(12);
    for (int i = 0; i < 5; i++) col_pkt(20, 12);
    expect_st(1'b1, 1'b0, "R6 stays partitioned");
    reconnect("R7 after long collision");

    rx = 1'b1; col = 1'b1; step(2049);
    rx = 1'b0; col = 1'b0; step(12);
    expect_st(1'b1, 1'b0, "R11 setup partition");
    rx = 1'b1;
    for (int i = 0; i < 1022; i++) begin
      tick = (i % 2 == 0);
      step(1);
    end
    expect_st(1'b1, 1'b0, "R11 511 ticks over 1022 cycles");
    tick = 1'b1; step(1);
    expect_st(1'b0, 1'b0, "R11 512th tick reconnects");
    step(50);
    rx = 1'b0; step(12);

    tx = 1'b1; step(30000);
    tx = 1'b0; step(1);
    tx = 1'b1; step(65536);
    expect_st(1'b0, 1'b0, "R2 R4 65536 ticks after a break");
    step(1);
    expect_st(1'b0, 1'b1, "R2 lock on 65537th tick");
    step(95);
    expect_st(1'b0, 1'b1, "R3 lock held 95 ticks");
    step(1);
    expect_st(1'b0, 1'b0, "R3 lock released after 96 ticks");
    step(200);
    expect_st(1'b0, 1'b0, "R3 count restarted after release");
    tx = 1'b0; step(20);

    step(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule